// File: doc/BRIEF.md
# CCK Receive Power Estimator

This block turns the one-byte automatic-gain report that arrives with each received CCK packet into measurements that link-management logic can use directly. The gain byte holds a low-noise-amplifier step and a variable-gain step. A piecewise gain table, which has a separate branch for high-power front-end mode, converts them into a received power in dBm. That power is clamped into a 0 to 100 percentage. When high-power mode is off, a boost curve then corrects the percentage.

From the corrected percentage the block derives two further values:

- A signal-quality figure. It is valid only for packets addressed from the associated network. It is either forced to full scale on strong signals, or computed from a separate quality report byte.
- A display strength on a fixed nonlinear scale, which expands the weak end of the range.

The upstream parser presents all inputs together with a one-cycle strobe. All results are captured into registers on that strobe and hold until the next one.

Top module: `cck_rx_power_est`

## Requirements
- R1: The gain byte is split with the amplifier step in bits 7:5 and the variable-gain step (g) in bits 4:0.
- R2: The table power in dBm depends on the amplifier step:
    - step 7: -100+2*(27-g) when g is 27 or less, otherwise -100.
    - step 6: -48+2*(2-g).
    - step 5: -42+2*(7-g).
    - step 4: -36+2*(7-g).
    - step 3: -24+2*(7-g).
    - step 1: 8-2*g.
    - step 0: 14-2*g.
- R3: Step 2 gives -12+2*(5-g) when high-power mode is set and -6+2*(5-g) otherwise. Every table result is raised by 6 dB, and that raised value appears on `pwr_dbm` as an 8-bit two's-complement number.
- R4: The raw percentage p is derived from the power as follows:
    - p is 0 when the power is at or below -100, or at or above 20.
    - p is 100 when the power is from 0 to 19.
    - p is 100 plus the power otherwise.
- R5: With high-power mode clear, p is corrected before it reaches `pwr_pct`:
    - When p is 80 or more, the result is 80+2*(p-80)+((p-80)>>1).
    - When p is from 20 to 78, the result is p+3.
    - Any result above 100 is limited to 100.
  With high-power mode set, p passes through unchanged.
- R6: With the network-match flag set, `sq_valid` is 1 and `sig_qual` is taken from the corrected percentage and the quality report r:
    - `sig_qual` is 100 when the corrected percentage exceeds 40 and test mode is clear.
    - Otherwise it is 0 for r above 64, 100 for r below 20, and (64-r)*100/44 with truncating division for r from 20 to 64.
- R7: With the network-match flag clear, `sig_qual` is 8'hFF and `sq_valid` is 0.
- R8: `disp_str` maps the corrected percentage x as follows:
    - 51..100 gives 100.
    - 41..50 gives 80+2*(x-40).
    - 31..40 gives 66+(x-30).
    - 21..30 gives 54+(x-20).
    - 10..20 gives 42+(2*(x-10))/3.
    - 5..9 gives 22+(3*(x-5))/2.
    - 1..4 gives 6+(3*(x-1))/2.
    - Any other x passes through unchanged.
- R9: Outputs change only on the clock edge that samples `in_valid` high, and show the result for the inputs presented at that edge. Inputs presented while `in_valid` is low have no effect.
- R10: A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: capture the current inputs |
| agc_byte | input | 8 | Gain report: amplifier step [7:5], variable-gain step [4:0] |
| sq_report | input | 8 | Raw quality report |
| high_pwr | input | 1 | High-power front-end mode |
| test_mode | input | 1 | Forces the report-based quality path |
| bss_match | input | 1 | Packet belongs to the associated network |
| pwr_dbm | output | 8 | Received power in dBm, two's complement |
| pwr_pct | output | 7 | Corrected power percentage, 0..100 |
| sig_qual | output | 8 | Signal quality 0..100, or 8'hFF when invalid |
| sq_valid | output | 1 | Signal quality is meaningful |
| disp_str | output | 7 | Display-scaled strength, 0..100 |

## Verification
The quality formula that uses the report byte is the hardest path to reach from the ports. Strong signals force quality to 100 whenever test mode is clear, so the formula is used only when the corrected percentage is 40 or less, which needs a very low power from the amplifier step and gain setting. The stimulus reaches it two ways. First, every gain byte is swept with test mode set. Second, the report byte is swept over all 256 values while the gain byte is fixed at maximum amplifier step and maximum gain, which yields -94 dBm and a 6 percent reading. The hold rule is checked after every capture by scrambling all inputs with the strobe low for one cycle.

// File: rtl/cck_est_pkg.sv
package cck_est_pkg;
    localparam int AGC_W   = 8;
    localparam int VGA_W   = 5;
    localparam int LNA_W   = AGC_W - VGA_W;
    localparam int DBM_W   = 8;
    localparam int PCT_W   = 7;
    localparam int Q_W     = 8;
    localparam int PCT_MAX = 100;
    localparam int DBM_ADJ = 6;
    localparam logic [Q_W-1:0] Q_INVALID = '1;
endpackage

// File: rtl/cck_gain_table.sv
module cck_gain_table
    import cck_est_pkg::*;
(
    input  logic [AGC_W-1:0]        agc,
    input  logic                    high_pwr,
    output logic signed [DBM_W-1:0] dbm
);
    logic [LNA_W-1:0] lna;
    logic [VGA_W-1:0] vga;
    int               g;
    int               base;

    always_comb begin
        lna = agc[AGC_W-1:VGA_W];
        vga = agc[VGA_W-1:0];
        g   = int'(vga);
        unique case (lna)
            3'd7:    base = (g <= 27) ? (-100 + 2 * (27 - g)) : -100;
            3'd6:    base = -48 + 2 * (2 - g);
            3'd5:    base = -42 + 2 * (7 - g);
            3'd4:    base = -36 + 2 * (7 - g);
            3'd3:    base = -24 + 2 * (7 - g);
            3'd2:    base = high_pwr ? (-12 + 2 * (5 - g)) : (-6 + 2 * (5 - g));
            3'd1:    base = 8 - 2 * g;
            default: base = 14 - 2 * g;
        endcase
        dbm = DBM_W'(base + DBM_ADJ);
    end
endmodule

// File: rtl/cck_pct_map.sv
module cck_pct_map
    import cck_est_pkg::*;
(
    input  logic signed [DBM_W-1:0] dbm,
    input  logic                    high_pwr,
    output logic [PCT_W-1:0]        pct
);
    int d;
    int p;
    int e;

    always_comb begin
        d = int'(dbm);
        if (d <= -100 || d >= 20) begin
            p = 0;
        end else if (d >= 0) begin
            p = PCT_MAX;
        end else begin
            p = PCT_MAX + d;
        end
        e = p - 80;
        if (!high_pwr) begin
            if (p >= 80) begin
                p = 80 + 2 * e + (e >>> 1);
            end else if (p >= 20 && p <= 78) begin
                p = p + 3;
            end
            if (p > PCT_MAX) begin
                p = PCT_MAX;
            end
        end
        pct = PCT_W'(p);
    end
endmodule

// File: rtl/cck_disp_scale.sv
module cck_disp_scale
    import cck_est_pkg::*;
(
    input  logic [PCT_W-1:0] pct,
    output logic [PCT_W-1:0] disp
);
    int x;
    int y;

    always_comb begin
        x = int'(pct);
        if (x >= 51 && x <= 100) begin
            y = 100;
        end else if (x >= 41 && x <= 50) begin
            y = 80 + 2 * (x - 40);
        end else if (x >= 31 && x <= 40) begin
            y = 66 + (x - 30);
        end else if (x >= 21 && x <= 30) begin
            y = 54 + (x - 20);
        end else if (x >= 10 && x <= 20) begin
            y = 42 + (2 * (x - 10)) / 3;
        end else if (x >= 5 && x <= 9) begin
            y = 22 + (3 * (x - 5)) / 2;
        end else if (x >= 1 && x <= 4) begin
            y = 6 + (3 * (x - 1)) / 2;
        end else begin
            y = x;
        end
        disp = PCT_W'(y);
    end
endmodule

// File: rtl/cck_quality.sv
module cck_quality
    import cck_est_pkg::*;
(
    input  logic [PCT_W-1:0] pct,
    input  logic [Q_W-1:0]   rpt,
    input  logic             test_mode,
    input  logic             bss_match,
    output logic [Q_W-1:0]   qual,
    output logic             qual_ok
);
    int r;
    int q;

    always_comb begin
        r = int'(rpt);
        if (int'(pct) > 40 && !test_mode) begin
            q = PCT_MAX;
        end else if (r > 64) begin
            q = 0;
        end else if (r < 20) begin
            q = PCT_MAX;
        end else begin
            q = ((64 - r) * 100) / 44;
        end
        qual    = bss_match ? Q_W'(q) : Q_INVALID;
        qual_ok = bss_match;
    end
endmodule

// File: rtl/cck_rx_power_est.sv
module cck_rx_power_est
    import cck_est_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [AGC_W-1:0]        agc_byte,
    input  logic [Q_W-1:0]          sq_report,
    input  logic                    high_pwr,
    input  logic                    test_mode,
    input  logic                    bss_match,
    output logic signed [DBM_W-1:0] pwr_dbm,
    output logic [PCT_W-1:0]        pwr_pct,
    output logic [Q_W-1:0]          sig_qual,
    output logic                    sq_valid,
    output logic [PCT_W-1:0]        disp_str
);
    logic signed [DBM_W-1:0] dbm_c;
    logic [PCT_W-1:0]        pct_c;
    logic [PCT_W-1:0]        disp_c;
    logic [Q_W-1:0]          qual_c;
    logic                    qok_c;

    cck_gain_table u_gain (
        .agc      (agc_byte),
        .high_pwr (high_pwr),
        .dbm      (dbm_c)
    );

    cck_pct_map u_pct (
        .dbm      (dbm_c),
        .high_pwr (high_pwr),
        .pct      (pct_c)
    );

    cck_disp_scale u_disp (
        .pct  (pct_c),
        .disp (disp_c)
    );

    cck_quality u_qual (
        .pct       (pct_c),
        .rpt       (sq_report),
        .test_mode (test_mode),
        .bss_match (bss_match),
        .qual      (qual_c),
        .qual_ok   (qok_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_dbm  <= '0;
            pwr_pct  <= '0;
            sig_qual <= '0;
            sq_valid <= 1'b0;
            disp_str <= '0;
        end else if (in_valid) begin
            pwr_dbm  <= dbm_c;
            pwr_pct  <= pct_c;
            sig_qual <= qual_c;
            sq_valid <= qok_c;
            disp_str <= disp_c;
        end
    end
endmodule

// File: rtl/cck_est_chk.sv
module cck_est_chk
    import cck_est_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    bss_match,
    input logic signed [DBM_W-1:0] pwr_dbm,
    input logic [PCT_W-1:0]        pwr_pct,
    input logic [Q_W-1:0]          sig_qual,
    input logic                    sq_valid,
    input logic [PCT_W-1:0]        disp_str
);
    AST_PCT_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(pwr_pct) <= PCT_MAX); // R4

    AST_DISP_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(disp_str) <= PCT_MAX); // R8

    AST_DBM_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(pwr_dbm) >= -100) && (int'(pwr_dbm) <= 20)); // R3

    AST_QUAL_RANGE: assert property (@(posedge clk) disable iff (rst)
        sq_valid |-> int'(sig_qual) <= PCT_MAX); // R6

    AST_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bss_match) |=> (sig_qual == Q_INVALID && !sq_valid)); // R7

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(pwr_dbm) && $stable(pwr_pct) && $stable(sig_qual)
                      && $stable(sq_valid) && $stable(disp_str))); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (pwr_dbm == '0 && pwr_pct == '0 && sig_qual == '0
                 && !sq_valid && disp_str == '0)); // R10
endmodule

bind cck_rx_power_est cck_est_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .bss_match (bss_match),
    .pwr_dbm   (pwr_dbm),
    .pwr_pct   (pwr_pct),
    .sig_qual  (sig_qual),
    .sq_valid  (sq_valid),
    .disp_str  (disp_str)
);

// File: tb/sim_cck_rx_power_est.sv
`timescale 1ns/1ps
module sim_cck_rx_power_est;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [7:0]        agc_byte = '0;
    logic [7:0]        sq_report = '0;
    logic              high_pwr = 1'b0;
    logic              test_mode = 1'b0;
    logic              bss_match = 1'b0;
    logic signed [7:0] pwr_dbm;
    logic [6:0]        pwr_pct;
    logic [7:0]        sig_qual;
    logic              sq_valid;
    logic [6:0]        disp_str;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cck_rx_power_est u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .agc_byte(agc_byte),
        .sq_report(sq_report), .high_pwr(high_pwr), .test_mode(test_mode),
        .bss_match(bss_match), .pwr_dbm(pwr_dbm), .pwr_pct(pwr_pct),
        .sig_qual(sig_qual), .sq_valid(sq_valid), .disp_str(disp_str)
    );

    // Reference model, written from the requirement text
    function automatic int ref_dbm(input logic [7:0] a, input logic hp);
        int s = int'(a[7:5]);
        int g = int'(a[4:0]);
        int t;
        case (s)
            7: t = (g > 27) ? -100 : -100 + 54 - 2 * g;
            6: t = -44 - 2 * g;
            5: t = -28 - 2 * g;
            4: t = -22 - 2 * g;
            3: t = -10 - 2 * g;
            2: t = hp ? (-2 - 2 * g) : (4 - 2 * g);
            1: t = 8 - 2 * g;
            default: t = 14 - 2 * g;
        endcase
        return t + 6;
    endfunction

    function automatic int ref_pct(input int d, input logic hp);
        int p;
        if (d <= -100 || d >= 20) p = 0;
        else if (d >= 0) p = 100;
        else p = 100 + d;
        if (!hp) begin
            if (p >= 80) p = 80 + 2 * (p - 80) + (p - 80) / 2;
            else if (p >= 20 && p <= 78) p = p + 3;
            if (p > 100) p = 100;
        end
        return p;
    endfunction

    function automatic int ref_qual(input int p, input int r, input logic tm, input logic m);
        if (!m) return 255;
        if (p > 40 && !tm) return 100;
        if (r > 64) return 0;
        if (r < 20) return 100;
        return ((64 - r) * 100) / 44;
    endfunction

    function automatic int ref_disp(input int x);
        if (x > 50) return 100;
        if (x > 40) return 2 * x;
        if (x > 30) return x + 36;
        if (x > 20) return x + 34;
        if (x >= 10) return 42 + (2 * x - 20) / 3;
        if (x >= 5) return 22 + (3 * x - 15) / 2;
        if (x >= 1) return 6 + (3 * x - 3) / 2;
        return x;
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s agc=%02h hp=%0d tm=%0d m=%0d sq=%0d: actual %0d expected %0d",
                     tag, agc_byte, high_pwr, test_mode, bss_match, sq_report, act, exp);
        end
    endtask

    task automatic check_all(input int d, input int p, input int q, input logic m, input string note);
        chk(int'(pwr_dbm), d, {"R1 R2 R3 dbm ", note});
        chk(int'(pwr_pct), p, {"R4 R5 pct ", note});
        chk(int'(sig_qual), q, m ? {"R6 qual ", note} : {"R7 qual ", note});
        chk(int'(sq_valid), int'(m), m ? {"R6 valid ", note} : {"R7 valid ", note});
        chk(int'(disp_str), ref_disp(p), {"R8 disp ", note});
    endtask

    task automatic apply(input logic [7:0] a, input logic [7:0] r,
                         input logic hp, input logic tm, input logic m);
        int d, p, q;
        @(negedge clk);
        agc_byte = a; sq_report = r; high_pwr = hp; test_mode = tm; bss_match = m;
        in_valid = 1'b1;
        d = ref_dbm(a, hp);
        p = ref_pct(d, hp);
        q = ref_qual(p, int'(r), tm, m);
        @(negedge clk);
        in_valid = 1'b0;
        check_all(d, p, q, m, "capture");
        // R9: scramble inputs with the strobe low; outputs must not move
        agc_byte = ~a; sq_report = ~r; high_pwr = ~hp; test_mode = ~tm; bss_match = ~m;
        @(negedge clk);
        check_all(d, p, q, m, "R9 hold");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(int'(pwr_dbm), 0, "R10 reset dbm");
        chk(int'(pwr_pct), 0, "R10 reset pct");
        chk(int'(sig_qual), 0, "R10 reset qual");
        chk(int'(sq_valid), 0, "R10 reset valid");
        chk(int'(disp_str), 0, "R10 reset disp");
        rst = 1'b0;

        // Every gain byte in every mode combination
        for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 8; k++) begin
                apply(8'(a), 8'((a * 7 + k * 13) % 90), k[0], k[1], k[2]);
            end
        end

        // Report-byte sweep on the formula path (-94 dBm, 6 percent)
        for (int r = 0; r < 256; r++) begin
            apply(8'hFF, 8'(r), 1'b0, 1'b0, 1'b1);
        end

        // R10: reset in mid-run clears captured values
        apply(8'h00, 8'd30, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(int'(pwr_dbm), 0, "R10 mid reset dbm");
        chk(int'(pwr_pct), 0, "R10 mid reset pct");
        chk(int'(disp_str), 0, "R10 mid reset disp");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule